// File: doc/BRIEF.md
# Comparator Trip Conditioner

This block turns the one-bit result of an analog comparator into trip signals for a PWM protection path. The raw bit can first be complemented. It then passes through a two-flop synchroniser and into a majority-vote filter. The filter keeps a sliding history of samples and moves its output to a new level only when enough samples in that history agree. A prescaler sets how often the filter takes a sample. A sticky fault latch is set by the filtered level. It stays set until a one-cycle clear pulse arrives while the filtered level is low.

Each of the two trip outputs has its own 2-bit source select. Code 0 picks the raw comparator bit after the inversion stage. Code 1 picks that bit after the synchroniser. Code 2 picks the filter output. Code 3 picks the latch. With the bypass enable set, the code-3 view is the latch ORed with the raw bit, so a fast fault reaches the trip without waiting for the filter. Every trip output is registered. A synchronous active-low reset clears the synchroniser, the sample history, the filter state, the latch and both outputs.

The filter has two states, FLT_LOW and FLT_HIGH. The transition FLT_LOW to FLT_HIGH (rise) happens when the count of ones in the active history reaches the vote threshold. The transition FLT_HIGH to FLT_LOW (fall) happens when the count of zeros reaches that threshold. Both transitions are taken only under a valid configuration.

The latch has two states, LAT_IDLE and LAT_HELD. The transition LAT_IDLE to LAT_HELD (arm) happens whenever the filter output is high. The transition LAT_HELD to LAT_IDLE (release) happens when the clear pulse is high and the filter output is low.

Top module: `cmp_trip_cond`

## Requirements
- R1: When `inv_en` is 1, the comparator bit is complemented before every path: raw, synchronised, filtered and latched.
- R2: Source code 0 gives the inverted-stage comparator bit, registered once. An input change shows on the trip output one clock later.
- R3: Source code 1 gives the bit after a two-flop synchroniser and the output register. An input change shows on the trip output three clocks later.
- R4: Source code 2 gives the filter output. With `presc` set to 1, the filter samples every clock. A steady change of input shows on the trip output `vote_min`+4 clocks after it is applied, for both rising and falling changes.
- R5: An input pulse that is shorter than `vote_min` samples does not change the filter output.
- R6: With `presc` = N (N ≥ 1), the filter samples once every N clocks. A value of 0 behaves like 1.
- R7: A one-cycle `filt_init` pulse loads every history position with the current synchronised input in a single clock. This lets the filter follow a new level one cycle earlier than shifting would allow.
- R8: Source code 3 gives the latch. Once the filter output has been high, the latch stays high after the filter output returns low, until it is cleared.
- R9: A one-cycle `latch_clr` pulse releases the latch while the filter output is low. The trip output falls one clock after the clear.
- R10: When the clear pulse and a high filter output occur in the same cycle, the latch stays set.
- R11: When `async_en` is 1, the code-3 source is the latch ORed with the raw inverted-stage bit. A one-clock comparator pulse then reaches the trip output, and it is not latched. When `async_en` is 0, the same pulse does not appear.
- R12: The filter output holds its value when the configuration is invalid. The configuration is invalid if `win_len` is 0, if `win_len` is above WIN_MAX, or if 2×`vote_min` ≤ `win_len`.
- R13: While `rst_n` is low at a clock edge, both trip outputs, the latch and the filter are cleared on that edge, and the sample history is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | 1 | Raw comparator result |
| inv_en | input | 1 | Complement the comparator result |
| async_en | input | 1 | OR the raw bit into the code-3 source |
| presc | input | PRE_W | Sample period in clocks (0 or 1 gives every clock) |
| win_len | input | CNT_W | Number of history samples used in the vote |
| vote_min | input | CNT_W | Agreeing samples needed to change level |
| filt_init | input | 1 | Load the whole history with the current input |
| latch_clr | input | 1 | Write-one-to-clear pulse for the latch |
| sel_a | input | 2 | Source select for trip_a (0 raw, 1 sync, 2 filter, 3 latch) |
| sel_b | input | 2 | Source select for trip_b (same encoding) |
| trip_a | output | 1 | Registered trip output A |
| trip_b | output | 1 | Registered trip output B |

## Verification
A table of steady comparator levels is run through each source code, with and without inversion. This shows that every path carries the right polarity and that the two selects act independently. Directed patterns then separate the filter timing cases. A held step measures the exact rise and fall latency. A pulse shorter than the threshold must be rejected. A slower prescale must stretch the latency into a known range. An init pulse must give a rise one clock earlier than shifting alone. The latch sequences cover three cases: a clear with the fault still active, a clear after the fault has gone, and a one-clock spike with the bypass on and off. An invalid threshold is shown to freeze the filter until a valid one is restored.

// File: rtl/cmp_trip_pkg.sv
package cmp_trip_pkg;

    typedef enum logic [1:0] {
        SRC_RAW   = 2'd0,
        SRC_SYNC  = 2'd1,
        SRC_FILT  = 2'd2,
        SRC_LATCH = 2'd3
    } trip_src_e;

    typedef enum logic {
        FLT_LOW  = 1'b0,
        FLT_HIGH = 1'b1
    } flt_state_e;

    typedef enum logic {
        LAT_IDLE = 1'b0,
        LAT_HELD = 1'b1
    } lat_state_e;

endpackage

// File: rtl/trip_sample_tick.sv
module trip_sample_tick #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] presc,
    output logic             tick
);

    logic [PRE_W-1:0] cnt_q;

    // A period of 0 or 1 samples on every clock.
    always_comb begin
        if (presc <= PRE_W'(1)) begin
            tick = 1'b1;
        end else begin
            tick = (cnt_q >= presc - PRE_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/trip_sync.sv
module trip_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/trip_vote_filter.sv
module trip_vote_filter
    import cmp_trip_pkg::*;
#(
    parameter int WIN_MAX = 16,
    parameter int CNT_W   = $clog2(WIN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             preload,
    input  logic             din,
    input  logic [CNT_W-1:0] win_len,
    input  logic [CNT_W-1:0] vote_min,
    output logic             level
);

    localparam logic [CNT_W:0] WIN_CAP = (CNT_W + 1)'(WIN_MAX);

    logic [WIN_MAX-1:0] hist_q;
    logic [WIN_MAX-1:0] in_win;
    logic [CNT_W-1:0]   ones;
    logic [CNT_W-1:0]   zeros;
    logic               cfg_ok;
    flt_state_e         st_q;
    flt_state_e         st_nx;

    // Mask of the history positions that take part in the vote.
    genvar g;
    generate
        for (g = 0; g < WIN_MAX; g++) begin : g_mask
            assign in_win[g] = (CNT_W'(g) < win_len);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (preload) begin
            hist_q <= {WIN_MAX{din}};
        end else if (sample_en) begin
            hist_q <= {hist_q[WIN_MAX-2:0], din};
        end
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < WIN_MAX; i++) begin
            ones = ones + CNT_W'(hist_q[i] & in_win[i]);
        end
        zeros = win_len - ones;
    end

    // The threshold must be a strict majority of a non-empty history that fits.
    assign cfg_ok = (win_len != '0)
                 && ({1'b0, win_len} <= WIN_CAP)
                 && ({vote_min, 1'b0} > {1'b0, win_len});

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            FLT_LOW:  if (cfg_ok && (ones >= vote_min))  st_nx = FLT_HIGH;
            FLT_HIGH: if (cfg_ok && (zeros >= vote_min)) st_nx = FLT_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FLT_LOW;
        else        st_q <= st_nx;
    end

    always_comb begin
        level = (st_q == FLT_HIGH);
    end

endmodule

// File: rtl/trip_fault_latch.sv
module trip_fault_latch
    import cmp_trip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_in,
    input  logic clr_in,
    output logic held
);

    lat_state_e st_q;
    lat_state_e st_nx;

    // A set in the same cycle as a clear wins, so a lasting fault is kept.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            LAT_IDLE: if (set_in)            st_nx = LAT_HELD;
            LAT_HELD: if (clr_in && !set_in) st_nx = LAT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LAT_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        held = (st_q == LAT_HELD);
    end

endmodule

// File: rtl/cmp_trip_cond.sv
module cmp_trip_cond
    import cmp_trip_pkg::*;
#(
    parameter  int WIN_MAX     = 16,
    parameter  int PRE_W       = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int CNT_W       = $clog2(WIN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_in,
    input  logic             inv_en,
    input  logic             async_en,
    input  logic [PRE_W-1:0] presc,
    input  logic [CNT_W-1:0] win_len,
    input  logic [CNT_W-1:0] vote_min,
    input  logic             filt_init,
    input  logic             latch_clr,
    input  logic [1:0]       sel_a,
    input  logic [1:0]       sel_b,
    output logic             trip_a,
    output logic             trip_b
);

    localparam int NUM_OUT = 2;

    logic       comp_x;
    logic       sync_bit;
    logic       sample_tick;
    logic       filt_q;
    logic       latch_q;
    logic       latch_view;
    logic [1:0] sel_vec [NUM_OUT];
    logic       trip_q  [NUM_OUT];

    assign comp_x = cmp_in ^ inv_en;

    trip_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (comp_x),
        .dout  (sync_bit)
    );

    trip_sample_tick #(.PRE_W(PRE_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .presc (presc),
        .tick  (sample_tick)
    );

    trip_vote_filter #(.WIN_MAX(WIN_MAX), .CNT_W(CNT_W)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_tick),
        .preload   (filt_init),
        .din       (sync_bit),
        .win_len   (win_len),
        .vote_min  (vote_min),
        .level     (filt_q)
    );

    trip_fault_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_in (filt_q),
        .clr_in (latch_clr),
        .held   (latch_q)
    );

    assign latch_view = latch_q | (async_en & comp_x);

    assign sel_vec[0] = sel_a;
    assign sel_vec[1] = sel_b;

    genvar o;
    generate
        for (o = 0; o < NUM_OUT; o++) begin : g_out
            logic pick;
            always_comb begin
                pick = 1'b0;
                unique case (trip_src_e'(sel_vec[o]))
                    SRC_RAW:   pick = comp_x;
                    SRC_SYNC:  pick = sync_bit;
                    SRC_FILT:  pick = filt_q;
                    SRC_LATCH: pick = latch_view;
                endcase
            end
            always_ff @(posedge clk) begin
                if (!rst_n) trip_q[o] <= 1'b0;
                else        trip_q[o] <= pick;
            end
        end
    endgenerate

    assign trip_a = trip_q[0];
    assign trip_b = trip_q[1];

endmodule

// File: rtl/cmp_trip_cond_chk.sv
module cmp_trip_cond_chk #(
    parameter int WIN_MAX = 16,
    parameter int CNT_W   = $clog2(WIN_MAX + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmp_in,
    input logic             inv_en,
    input logic [CNT_W-1:0] win_len,
    input logic [CNT_W-1:0] vote_min,
    input logic             latch_clr,
    input logic [1:0]       sel_a,
    input logic             trip_a,
    input logic             trip_b,
    input logic             filt_q,
    input logic             latch_q
);

    logic bad_cfg;
    assign bad_cfg = (win_len == '0)
                  || (int'(win_len) > WIN_MAX)
                  || ((int'(vote_min) * 2) <= int'(win_len));

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!trip_a && !trip_b && !latch_q && !filt_q)); // R13

    AST_RAW_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == 2'd0) |=> (trip_a == $past(cmp_in ^ inv_en))); // R2

    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !latch_clr) |=> latch_q); // R8

    AST_LATCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && latch_clr && !filt_q) |=> !latch_q); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        filt_q |=> latch_q); // R10

    AST_BAD_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cfg |=> $stable(filt_q)); // R12

endmodule

bind cmp_trip_cond cmp_trip_cond_chk #(.WIN_MAX(WIN_MAX), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_in    (cmp_in),
    .inv_en    (inv_en),
    .win_len   (win_len),
    .vote_min  (vote_min),
    .latch_clr (latch_clr),
    .sel_a     (sel_a),
    .trip_a    (trip_a),
    .trip_b    (trip_b),
    .filt_q    (filt_q),
    .latch_q   (latch_q)
);

// File: tb/cmp_trip_cond_test.sv
module cmp_trip_cond_test;

    localparam int CLK_PERIOD = 10;
    localparam int WIN_MAX    = 16;
    localparam int PRE_W      = 8;
    localparam int CNT_W      = $clog2(WIN_MAX + 1);

    // Row fields: [5] cmp, [4] inv, [3] async, [2:1] select, [0] expected trip
    localparam int NVEC = 10;
    localparam logic [5:0] VEC [NVEC] = '{
        6'b1_0_0_00_1, 6'b1_1_0_00_0, 6'b0_1_0_01_1, 6'b0_0_0_01_0,
        6'b1_0_0_10_1, 6'b1_1_0_10_0, 6'b0_1_0_11_1, 6'b0_0_0_11_0,
        6'b1_1_1_11_0, 6'b1_0_1_11_1
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cmp_in, inv_en, async_en, filt_init, latch_clr;
    logic [PRE_W-1:0] presc;
    logic [CNT_W-1:0] win_len, vote_min;
    logic [1:0]       sel_a, sel_b;
    logic             trip_a, trip_b;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmp_trip_cond #(.WIN_MAX(WIN_MAX), .PRE_W(PRE_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .inv_en(inv_en),
        .async_en(async_en), .presc(presc), .win_len(win_len),
        .vote_min(vote_min), .filt_init(filt_init), .latch_clr(latch_clr),
        .sel_a(sel_a), .sel_b(sel_b), .trip_a(trip_a), .trip_b(trip_b)
    );

    task automatic tick_n(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wait_a(input logic lvl, output int k);
        k = 0;
        for (int n = 1; n <= 60; n++) begin
            tick_n(1);
            if (trip_a === lvl) begin
                k = n;
                break;
            end
        end
    endtask

    task automatic clr_pulse();
        latch_clr = 1'b1;
        tick_n(1);
        latch_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int k;
        string tag;
        rst_n = 1'b0; cmp_in = 1'b1; inv_en = 1'b0; async_en = 1'b0;
        filt_init = 1'b0; latch_clr = 1'b0; presc = PRE_W'(1);
        win_len = CNT_W'(5); vote_min = CNT_W'(3);
        sel_a = 2'd0; sel_b = 2'd1;
        tick_n(3);
        chk("R13 reset trip_a", trip_a, 1'b0);
        chk("R13 reset trip_b", trip_b, 1'b0);
        cmp_in = 1'b0;
        rst_n = 1'b1;
        tick_n(12);

        // Table walk: steady levels through every source code
        for (int r = 0; r < NVEC; r++) begin
            cmp_in   = VEC[r][5];
            inv_en   = VEC[r][4];
            async_en = VEC[r][3];
            sel_a    = VEC[r][2:1];
            sel_b    = VEC[r][2:1];
            tick_n(12);
            clr_pulse();
            tick_n(3);
            case (VEC[r][2:1])
                2'd0:    tag = "R1/R2 table";
                2'd1:    tag = "R1/R3 table";
                2'd2:    tag = "R1/R4 table";
                default: tag = "R1/R8 table";
            endcase
            chk(tag, trip_a, VEC[r][0]);
            chk(tag, trip_b, VEC[r][0]);
        end

        inv_en = 1'b0; async_en = 1'b0; cmp_in = 1'b0;
        tick_n(12);
        clr_pulse();
        tick_n(2);

        // R2 / R3 latency
        sel_a = 2'd0; sel_b = 2'd1;
        cmp_in = 1'b1;
        tick_n(1);
        chk("R2 one clock", trip_a, 1'b1);
        chk("R3 not at 1", trip_b, 1'b0);
        tick_n(1);
        chk("R3 not at 2", trip_b, 1'b0);
        tick_n(1);
        chk("R3 at 3", trip_b, 1'b1);
        cmp_in = 1'b0;
        tick_n(12);

        // R4 exact rise and fall latency
        sel_a = 2'd2; sel_b = 2'd2;
        cmp_in = 1'b1;
        wait_a(1'b1, k);
        chk_int("R4 rise latency", k, 7, 7);
        tick_n(10);
        cmp_in = 1'b0;
        wait_a(1'b0, k);
        chk_int("R4 fall latency", k, 7, 7);
        tick_n(10);

        // R5 short pulse rejected
        begin
            logic seen;
            seen = 1'b0;
            cmp_in = 1'b1;
            tick_n(2);
            cmp_in = 1'b0;
            for (int n = 0; n < 12; n++) begin
                tick_n(1);
                seen = seen | trip_a;
            end
            chk("R5 glitch", seen, 1'b0);
        end

        // R6 prescaled sampling
        presc = PRE_W'(3);
        cmp_in = 1'b1;
        wait_a(1'b1, k);
        chk_int("R6 prescale latency", k, 11, 13);
        cmp_in = 1'b0;
        tick_n(25);
        presc = PRE_W'(0);
        cmp_in = 1'b1;
        wait_a(1'b1, k);
        chk_int("R6 zero period", k, 7, 7);
        cmp_in = 1'b0;
        tick_n(12);
        presc = PRE_W'(1);

        // R7 history preload
        cmp_in = 1'b1;
        tick_n(3);
        filt_init = 1'b1;
        tick_n(1);
        filt_init = 1'b0;
        tick_n(2);
        chk("R7 preload early rise", trip_a, 1'b1);
        cmp_in = 1'b0;
        tick_n(12);

        // R8 / R9 / R10 latch behaviour
        sel_a = 2'd2; sel_b = 2'd3;
        clr_pulse();
        tick_n(1);
        chk("R9 clear after fault gone", trip_b, 1'b0);
        cmp_in = 1'b1;
        tick_n(10);
        chk("R8 latch set", trip_b, 1'b1);
        clr_pulse();
        tick_n(3);
        chk("R10 set beats clear", trip_b, 1'b1);
        cmp_in = 1'b0;
        tick_n(12);
        chk("R8 filter low", trip_a, 1'b0);
        chk("R8 latch held", trip_b, 1'b1);
        clr_pulse();
        tick_n(1);
        chk("R9 clear releases", trip_b, 1'b0);

        // R11 bypass of the filter
        async_en = 1'b1;
        cmp_in = 1'b1;
        tick_n(1);
        chk("R11 spike passes", trip_b, 1'b1);
        cmp_in = 1'b0;
        tick_n(1);
        chk("R11 spike ends", trip_b, 1'b0);
        tick_n(10);
        chk("R11 spike not latched", trip_b, 1'b0);
        async_en = 1'b0;
        cmp_in = 1'b1;
        tick_n(1);
        chk("R11 spike blocked", trip_b, 1'b0);
        cmp_in = 1'b0;
        tick_n(12);

        // R12 invalid threshold freezes the filter
        win_len = CNT_W'(6); vote_min = CNT_W'(3);
        cmp_in = 1'b1;
        tick_n(20);
        chk("R12 frozen", trip_a, 1'b0);
        vote_min = CNT_W'(4);
        tick_n(4);
        chk("R12 resumes", trip_a, 1'b1);

        // R13 reset during run
        tick_n(4);
        rst_n = 1'b0;
        tick_n(1);
        chk("R13 run reset trip_a", trip_a, 1'b0);
        chk("R13 run reset trip_b", trip_b, 1'b0);
        cmp_in = 1'b0;
        rst_n = 1'b1;
        tick_n(8);
        chk("R13 latch emptied", trip_b, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule